// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB panel. From one source clock it makes a pixel strobe, a horizontal sync, a vertical sync and a data-enable that marks the visible area. Pixel data and register decoding stay outside the block. Configuration arrives as plain input fields, which a register file elsewhere holds.

Each line consists of a sync pulse, a back porch, the active pixels and a front porch, in that order. Each frame has the same four parts, counted in lines. Every length field holds its count minus one. A programmable divider slows the pixel strobe when it is enabled; otherwise a pixel advances on every source cycle. Each panel-facing signal can be inverted on its own.

Output starts only when both the immediate run bit and its frame-synchronous twin are set. The twin only changes at a frame boundary. A frame interrupt can be raised at the start of each vertical sync. Its status bit is cleared by a write-one pulse.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each length field stores its count minus one. A line lasts hsw+hbp+hact+hfp+4 pixel strobes and a frame lasts vsw+vbp+vact+vfp+4 lines, where each name is the raw field value.
- R2: Horizontal sync is asserted for pixels 0 to hsw of a line. The back porch follows, then hact+1 active pixels starting at pixel hsw+hbp+2, then the front porch.
- R3: Vertical sync is asserted for whole lines 0 to vsw of a frame. The vertical back porch follows, then vact+1 active lines starting at line vsw+vbp+2, then the vertical front porch.
- R4: Data enable is asserted only when the pixel lies in the active region horizontally and the line lies in the active region vertically.
- R5: With div_en high, the pixel strobe pclk_en pulses once every div_m1+1 source cycles while running. With div_en low, it is high on every source cycle while running.
- R6: Each output lcd_hsync, lcd_vsync, lcd_de and lcd_pclk equals its true-polarity value XOR its inversion bit. While stopped, the true-polarity values are all 0.
- R7: The generator runs only while disp_en is high and the latched frame enable is set. A stopped generator restarts from pixel 0 of line 0. While stopped, the latched frame enable follows disp_en_frame each cycle. While running, it samples disp_en_frame only on the last pixel strobe of a frame.
- R8: irq_status sets on the pixel strobe of pixel 0 of line 0 when both irq_en and irq_sel are high. A pulse on irq_clr clears it. A set in the same cycle wins over the clear, and the status holds otherwise.
- R9: irq is high exactly when irq_status and irq_en are both high.
- R10: After reset the counters are at pixel 0 of line 0, the divider is cleared, the latched frame enable is 0 and irq_status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsw | input | TW | Horizontal sync width minus one |
| hbp | input | TW | Horizontal back porch minus one |
| hact | input | TW | Active width minus one |
| hfp | input | TW | Horizontal front porch minus one |
| vsw | input | TW | Vertical sync width minus one |
| vbp | input | TW | Vertical back porch minus one |
| vact | input | TW | Active height minus one |
| vfp | input | TW | Vertical front porch minus one |
| inv_hs | input | 1 | Invert horizontal sync |
| inv_vs | input | 1 | Invert vertical sync |
| inv_de | input | 1 | Invert data enable |
| inv_pclk | input | 1 | Invert pixel clock output |
| div_en | input | 1 | Use the divider |
| div_m1 | input | DW | Divisor minus one |
| disp_en | input | 1 | Immediate run bit |
| disp_en_frame | input | 1 | Run bit applied at frame boundary |
| irq_en | input | 1 | Frame interrupt enable |
| irq_sel | input | 1 | Select vsync as interrupt source |
| irq_clr | input | 1 | Write-one-to-clear pulse for status |
| pclk_en | output | 1 | Pixel strobe, true polarity |
| lcd_pclk | output | 1 | Pixel clock to panel |
| lcd_hsync | output | 1 | Horizontal sync to panel |
| lcd_vsync | output | 1 | Vertical sync to panel |
| lcd_de | output | 1 | Data enable to panel |
| irq_status | output | 1 | Frame interrupt status |
| irq | output | 1 | Frame interrupt request |

## Verification
The assertions check on every cycle the relations between the outputs. Data enable never overlaps either sync. The interrupt line always matches status AND enable, and the status only falls after a clear pulse. The divider never strobes on two cycles in a row when its divisor exceeds one. Nothing strobes without disp_en, and the sync outputs sit at their idle levels while stopped.

Only the bench's scenarios can show that the absolute region boundaries follow the minus-one fields. Several things depend on a running reference of the raster and are checked there: the deferred effect of the frame-synchronous enable, the restart after a stop, and when the interrupt is set against when it is cleared.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int TW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] hsw,
  input  logic [TW-1:0] hbp,
  input  logic [TW-1:0] hact,
  input  logic [TW-1:0] hfp,
  input  logic [TW-1:0] vsw,
  input  logic [TW-1:0] vbp,
  input  logic [TW-1:0] vact,
  input  logic [TW-1:0] vfp,
  input  logic          inv_hs,
  input  logic          inv_vs,
  input  logic          inv_de,
  input  logic          inv_pclk,
  input  logic          div_en,
  input  logic [DW-1:0] div_m1,
  input  logic          disp_en,
  input  logic          disp_en_frame,
  input  logic          irq_en,
  input  logic          irq_sel,
  input  logic          irq_clr,
  output logic          pclk_en,
  output logic          lcd_pclk,
  output logic          lcd_hsync,
  output logic          lcd_vsync,
  output logic          lcd_de,
  output logic          irq_status,
  output logic          irq
);
  localparam int CW = TW + 2;

  logic [CW-1:0] hcnt, vcnt;
  logic [DW-1:0] dcnt;
  logic          frame_q;

  logic [CW-1:0] h_sw, h_bp, h_ac, h_fp, v_sw, v_bp, v_ac, v_fp;
  assign h_sw = CW'(hsw);
  assign h_bp = CW'(hbp);
  assign h_ac = CW'(hact);
  assign h_fp = CW'(hfp);
  assign v_sw = CW'(vsw);
  assign v_bp = CW'(vbp);
  assign v_ac = CW'(vact);
  assign v_fp = CW'(vfp);

  logic [CW-1:0] h_first, h_lastact, h_end, v_first, v_lastact, v_end;
  assign h_first   = h_sw + h_bp + CW'(2);
  assign h_lastact = h_first + h_ac;
  assign h_end     = h_lastact + h_fp + CW'(1);
  assign v_first   = v_sw + v_bp + CW'(2);
  assign v_lastact = v_first + v_ac;
  assign v_end     = v_lastact + v_fp + CW'(1);

  logic running, line_last, frame_last;
  assign running    = disp_en & frame_q;
  assign pclk_en    = running & (~div_en | (dcnt == div_m1));
  assign line_last  = hcnt == h_end;
  assign frame_last = line_last & (vcnt == v_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
    end else if (!running || !div_en || dcnt == div_m1) begin
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!running) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pclk_en) begin
      if (line_last) begin
        hcnt <= '0;
        vcnt <= (vcnt == v_end) ? '0 : vcnt + CW'(1);
      end else begin
        hcnt <= hcnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frame_q <= 1'b0;
    else if (!running || (pclk_en && frame_last))
      frame_q <= disp_en_frame;
  end

  logic hs_t, vs_t, de_t;
  assign hs_t = running & (hcnt <= h_sw);
  assign vs_t = running & (vcnt <= v_sw);
  assign de_t = running & (hcnt >= h_first) & (hcnt <= h_lastact)
                        & (vcnt >= v_first) & (vcnt <= v_lastact);

  assign lcd_hsync = hs_t ^ inv_hs;
  assign lcd_vsync = vs_t ^ inv_vs;
  assign lcd_de    = de_t ^ inv_de;
  assign lcd_pclk  = pclk_en ^ inv_pclk;

  logic vs_start;
  assign vs_start = pclk_en & (hcnt == '0) & (vcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_status <= 1'b0;
    else if (vs_start && irq_en && irq_sel)
      irq_status <= 1'b1;
    else if (irq_clr)
      irq_status <= 1'b0;
  end

  assign irq = irq_status & irq_en;
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int TW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inv_hs,
  input logic          inv_vs,
  input logic          inv_de,
  input logic          div_en,
  input logic [DW-1:0] div_m1,
  input logic          disp_en,
  input logic          irq_en,
  input logic          irq_clr,
  input logic          pclk_en,
  input logic          lcd_hsync,
  input logic          lcd_vsync,
  input logic          lcd_de,
  input logic          irq_status,
  input logic          irq
);
  logic hs_t, vs_t, de_t;
  assign hs_t = lcd_hsync ^ inv_hs;
  assign vs_t = lcd_vsync ^ inv_vs;
  assign de_t = lcd_de ^ inv_de;

  AST_DE_NOT_IN_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_t |-> !hs_t); // R4
  AST_DE_NOT_IN_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de_t |-> !vs_t); // R4
  AST_DIV_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_en && div_en && div_m1 != '0) |=> (!pclk_en || !div_en || div_m1 == '0)); // R5
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (!pclk_en && !hs_t && !vs_t && !de_t)); // R6
  AST_STATUS_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_status) |-> $past(irq_clr)); // R8
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status && !irq_clr) |=> irq_status); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_status && irq_en)); // R9
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.TW(TW), .DW(DW)) u_chk (.*);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;
  localparam int TW = 12;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
  logic inv_hs, inv_vs, inv_de, inv_pclk, div_en;
  logic [DW-1:0] div_m1;
  logic disp_en, disp_en_frame, irq_en, irq_sel, irq_clr;
  logic pclk_en, lcd_pclk, lcd_hsync, lcd_vsync, lcd_de, irq_status, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lcd_timing_gen #(.TW(TW), .DW(DW)) dut (.*);

  typedef struct packed {
    logic pe, pc, hs, vs, de, st, iq;
  } exp_t;
  exp_t sb[$];

  int m_h = 0, m_v = 0, m_d = 0;
  bit m_fr = 0, m_st = 0;

  function automatic exp_t model_out();
    exp_t e;
    bit act, hs, vs, de;
    int hf, vf;
    act = disp_en && m_fr;
    hf = int'(hsw) + int'(hbp) + 2;
    vf = int'(vsw) + int'(vbp) + 2;
    e.pe = act && (!div_en || m_d == int'(div_m1));
    hs = act && (m_h <= int'(hsw));
    vs = act && (m_v <= int'(vsw));
    de = act && m_h >= hf && m_h <= hf + int'(hact) && m_v >= vf && m_v <= vf + int'(vact);
    e.pc = e.pe ^ inv_pclk;
    e.hs = hs ^ inv_hs;
    e.vs = vs ^ inv_vs;
    e.de = de ^ inv_de;
    e.st = m_st;
    e.iq = m_st && irq_en;
    return e;
  endfunction

  // Reference raster: update on each edge, then push the expected outputs.
  always @(posedge clk) begin
    bit act, tick, fl;
    int hl, vl;
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_d = 0; m_fr = 0; m_st = 0;
    end else begin
      hl = int'(hsw) + int'(hbp) + int'(hact) + int'(hfp) + 3;
      vl = int'(vsw) + int'(vbp) + int'(vact) + int'(vfp) + 3;
      act = disp_en && m_fr;
      tick = act && (!div_en || m_d == int'(div_m1));
      fl = (m_h == hl) && (m_v == vl);
      if (tick && m_h == 0 && m_v == 0 && irq_en && irq_sel) m_st = 1;
      else if (irq_clr) m_st = 0;
      if (!act || (tick && fl)) m_fr = disp_en_frame;
      if (!act || !div_en || m_d == int'(div_m1)) m_d = 0; else m_d = m_d + 1;
      if (!act) begin m_h = 0; m_v = 0; end
      else if (tick) begin
        if (m_h == hl) begin m_h = 0; m_v = (m_v == vl) ? 0 : m_v + 1; end
        else m_h = m_h + 1;
      end
    end
    #3;
    sb.push_back(model_out());
  end

  task automatic cmp(input logic a, input logic e, input string what);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", what, a, e, $time);
    end
  endtask

  // Monitor: pop one expected item per cycle and compare away from the edge.
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0 && !done) begin
      e = sb.pop_front();
      cmp(pclk_en,    e.pe, "R5 pclk_en");
      cmp(lcd_pclk,   e.pc, "R6 lcd_pclk");
      cmp(lcd_hsync,  e.hs, "R1/R2/R6/R7 hsync");
      cmp(lcd_vsync,  e.vs, "R1/R3/R6/R7 vsync");
      cmp(lcd_de,     e.de, "R4/R6 data enable");
      cmp(irq_status, e.st, "R8 irq_status");
      cmp(irq,        e.iq, "R9 irq");
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_timing(input int a, b, c, d, e, f, g, h);
    hsw = TW'(a); hbp = TW'(b); hact = TW'(c); hfp = TW'(d);
    vsw = TW'(e); vbp = TW'(f); vact = TW'(g); vfp = TW'(h);
  endtask

  initial begin
    set_timing(1, 0, 3, 0, 0, 0, 1, 0);
    {inv_hs, inv_vs, inv_de, inv_pclk} = '0;
    div_en = 0; div_m1 = '0;
    disp_en = 0; disp_en_frame = 0;
    irq_en = 0; irq_sel = 0; irq_clr = 0;
    run(3);
    rst_n = 1'b1;
    run(1);
    @(negedge clk);
    // R10: reset state seen at the ports
    cmp(pclk_en, 1'b0, "R10 pclk_en after reset");
    cmp(irq_status, 1'b0, "R10 irq_status after reset");
    cmp(lcd_hsync, 1'b0, "R10 hsync idle after reset");
    run(1);
    // Bypass, two 8x5 frames with interrupts
    irq_en = 1; irq_sel = 1;
    disp_en = 1; disp_en_frame = 1;
    run(85);
    irq_clr = 1; run(1); irq_clr = 0;
    run(20);
    // Divider by 3
    div_en = 1; div_m1 = 8'd2;
    run(260);
    // Different timing and inverted polarities, restart via disp_en
    disp_en = 0; run(2);
    set_timing(0, 1, 1, 2, 1, 0, 2, 1);
    {inv_hs, inv_vs, inv_de, inv_pclk} = 4'b1111;
    div_en = 0;
    disp_en = 1;
    run(150);
    // Drop the frame twin mid-frame: stops only at frame end
    run(13);
    disp_en_frame = 0;
    run(120);
    disp_en_frame = 1;
    run(30);
    // Drop disp_en mid-frame, restart at pixel 0
    disp_en = 0; run(3); disp_en = 1;
    run(60);
    // Interrupt gating: enable off, source off, clear racing a set
    irq_en = 0; run(50);
    irq_en = 1; irq_sel = 0; irq_clr = 1; run(1); irq_clr = 0;
    run(80);
    irq_sel = 1; irq_clr = 1;
    run(200);
    irq_clr = 0;
    run(40);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule